// File: doc/BRIEF.md
# Frequency-Modulation Voice Bank

This block produces one signed audio sample for each pulse on its sample strobe. It holds a fixed set of voices, and each voice pairs two phase-accumulator oscillators. The first oscillator, the modulator, runs at a frequency word that all voices share. It produces a signed waveform sample. That sample is scaled by a power of two and added to the voice's own base frequency word. The result becomes the phase increment of the second oscillator, the carrier, in the same sample period.

The carrier samples of all voices are added together without weighting into one wide signed result. A one-cycle valid pulse marks that result. A controller drives the per-voice base words, the note-enable bits, the shared modulator word and the modulation-index shift. It may change them only between strobes, and it spaces strobes at least four clock cycles apart.

Top module: `fmVoiceBank`

## Requirements
- R1: After reset, every oscillator phase is zero, `sampleOut` is zero and `sampleValid` is low.
- R2: `sampleValid` is high for exactly one cycle. It rises three clock edges after the edge that samples `sampleStrobe` high, and `sampleOut` holds the new sum while it is high.
- R3: On each strobe, the modulator of every enabled voice adds `modFcw` to its 24-bit phase, modulo 2^24. The modulator sample used in that period is the waveform of the updated phase.
- R4: In the same period, the carrier of every enabled voice adds an increment to its phase. The increment is its base word plus the modulator sample, sign-extended to 24 bits and shifted left by `modShift` (0 to 15), all modulo 2^24.
- R5: When a voice's enable bit is low, neither of its phases advances. Its carrier still contributes the waveform of its held phase to the sum.
- R6: `sampleOut` is the exact signed sum of the four carrier samples, 18 bits wide, with no scaling.
- R7: The waveform uses address a = phase[23:14] and x = a mod 512. Its magnitude is min((x*(512-x))>>1, 32767), and the value is negative when a >= 512. For example, x=0 gives 0, x=1 gives 255, x=128 gives 24576 and x=256 gives 32767.
- R8: Without a strobe, no phase changes. The next sample after an idle gap follows from the state left by the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleStrobe | input | 1 | Starts one sample computation |
| baseFcw | input | 96 | Base frequency words, voice v in bits [24v+23:24v] |
| noteOn | input | 4 | Per-voice enable, bit v for voice v |
| modFcw | input | 24 | Shared modulator frequency word |
| modShift | input | 4 | Modulation-index left shift, 0 to 15 |
| sampleOut | output | 18 | Signed sum of carrier samples |
| sampleValid | output | 1 | One-cycle pulse when sampleOut is new |

## Verification
A single voice is first run with no modulation and a base word of one address step, over 1024 strobes. This walks every waveform address, so any table error shows apart from the modulation path. All sixteen enable patterns are then tried with distinct base words, a nonzero shared modulator word and every shift from 0 to 15. These cases separate gating faults, faults in sign extension or shifting of negative modulator samples, and faults in summation. An idle gap between strobes, and a wait with all voices disabled, show whether any phase moves without a strobe. On every sample the bench also checks the exact cycle and width of the valid pulse.

// File: rtl/fmPkg.sv
package fmPkg;
  typedef struct packed {
    logic advMod;
    logic advCar;
    logic latchSum;
  } fmStrobes_t;
endpackage

// File: rtl/fmWaveLut.sv
module fmWaveLut #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 16
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] value
);
  localparam int HALF   = 1 << (ADDR_W - 1);
  localparam int PROD_W = 2 * ADDR_W;
  localparam int DROP   = 2 * (ADDR_W - 1) - 2 - (SAMP_W - 1);
  localparam int MAXV   = (1 << (SAMP_W - 1)) - 1;

  logic [ADDR_W-1:0] xPos;
  logic [ADDR_W-1:0] xRem;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] mag;
  logic [SAMP_W-1:0] magClamped;

  always_comb begin
    xPos = {1'b0, addr[ADDR_W-2:0]};
    xRem = ADDR_W'(HALF) - xPos;
    prod = PROD_W'(xPos) * PROD_W'(xRem);
    mag  = prod >> DROP;
    if (mag > PROD_W'(MAXV)) magClamped = SAMP_W'(MAXV);
    else                     magClamped = mag[SAMP_W-1:0];
    if (addr[ADDR_W-1]) value = -$signed(magClamped);
    else                value = $signed(magClamped);
  end
endmodule

// File: rtl/fmOsc.sv
module fmOsc #(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic [PHASE_W-1:0]       phaseInc,
  output logic [PHASE_W-1:0]       phase,
  output logic signed [SAMP_W-1:0] sample
);
  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (advance) phase <= phase + phaseInc;
  end

  fmWaveLut #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) lut (
    .addr  (phase[PHASE_W-1 -: ADDR_W]),
    .value (sample)
  );
endmodule

// File: rtl/fmControl.sv
module fmControl
  import fmPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleStrobe,
  output fmStrobes_t strobes,
  output logic       sampleValid
);
  logic [2:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage       <= '0;
      sampleValid <= 1'b0;
    end else begin
      stage       <= {stage[1:0], sampleStrobe};
      sampleValid <= stage[2];
    end
  end

  always_comb begin
    strobes.advMod   = stage[0];
    strobes.advCar   = stage[1];
    strobes.latchSum = stage[2];
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(sampleStrobe, 4)) else $error("valid latency"); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid) else $error("valid width"); // R2
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |-> (stage == 3'b000)) else $error("strobes too close"); // R2
endmodule

// File: rtl/fmDatapath.sv
module fmDatapath
  import fmPkg::*;
#(
  parameter int VOICES  = 4,
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 16,
  parameter int SHIFT_W = 4,
  parameter int OUT_W   = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  fmStrobes_t                 strobes,
  input  logic [VOICES*PHASE_W-1:0]  baseFcw,
  input  logic [VOICES-1:0]          noteOn,
  input  logic [PHASE_W-1:0]         modFcw,
  input  logic [SHIFT_W-1:0]         modShift,
  output logic signed [OUT_W-1:0]    sampleOut
);
  localparam int EXT_W = PHASE_W - SAMP_W;

  logic signed [SAMP_W-1:0] modSample [VOICES];
  logic signed [SAMP_W-1:0] carSample [VOICES];
  logic [PHASE_W-1:0]       modPhase  [VOICES];
  logic [PHASE_W-1:0]       carPhase  [VOICES];
  logic [PHASE_W-1:0]       carInc    [VOICES];
  logic signed [OUT_W-1:0]  sumNext;

  for (genvar v = 0; v < VOICES; v++) begin : gVoice
    logic [PHASE_W-1:0] modExt;

    always_comb begin
      modExt    = {{EXT_W{modSample[v][SAMP_W-1]}}, modSample[v]};
      carInc[v] = baseFcw[v*PHASE_W +: PHASE_W] + (modExt << modShift);
    end

    fmOsc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) modOsc (
      .clk      (clk),
      .rst      (rst),
      .advance  (strobes.advMod & noteOn[v]),
      .phaseInc (modFcw),
      .phase    (modPhase[v]),
      .sample   (modSample[v])
    );

    fmOsc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) carOsc (
      .clk      (clk),
      .rst      (rst),
      .advance  (strobes.advCar & noteOn[v]),
      .phaseInc (carInc[v]),
      .phase    (carPhase[v]),
      .sample   (carSample[v])
    );

    AST_OFF_HOLDS_CARRIER: assert property (@(posedge clk) disable iff (rst)
      !noteOn[v] |=> $stable(carPhase[v])) else $error("carrier moved while off"); // R5
    AST_OFF_HOLDS_MODULATOR: assert property (@(posedge clk) disable iff (rst)
      !noteOn[v] |=> $stable(modPhase[v])) else $error("modulator moved while off"); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!strobes.advMod && !strobes.advCar) |=> ($stable(modPhase[v]) && $stable(carPhase[v])))
      else $error("phase moved without strobe"); // R8
  end

  always_comb begin
    sumNext = '0;
    for (int v = 0; v < VOICES; v++) sumNext = sumNext + OUT_W'(carSample[v]);
  end

  always_ff @(posedge clk) begin
    if (rst)                   sampleOut <= '0;
    else if (strobes.latchSum) sampleOut <= sumNext;
  end

  AST_MOD_BEFORE_CARRIER: assert property (@(posedge clk) disable iff (rst)
    strobes.advCar |-> $past(strobes.advMod)) else $error("carrier before modulator"); // R4
  AST_SUM_AFTER_CARRIER: assert property (@(posedge clk) disable iff (rst)
    strobes.latchSum |-> $past(strobes.advCar)) else $error("sum before carrier"); // R6
endmodule

// File: rtl/fmVoiceBank.sv
module fmVoiceBank
  import fmPkg::*;
#(
  parameter int VOICES  = 4,
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 16,
  parameter int SHIFT_W = 4,
  parameter int OUT_W   = SAMP_W + $clog2(VOICES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sampleStrobe,
  input  logic [VOICES*PHASE_W-1:0] baseFcw,
  input  logic [VOICES-1:0]         noteOn,
  input  logic [PHASE_W-1:0]        modFcw,
  input  logic [SHIFT_W-1:0]        modShift,
  output logic signed [OUT_W-1:0]   sampleOut,
  output logic                      sampleValid
);
  fmStrobes_t strobes;

  fmControl ctrl (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .strobes      (strobes),
    .sampleValid  (sampleValid)
  );

  fmDatapath #(
    .VOICES(VOICES), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W),
    .SAMP_W(SAMP_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
  ) dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .baseFcw   (baseFcw),
    .noteOn    (noteOn),
    .modFcw    (modFcw),
    .modShift  (modShift),
    .sampleOut (sampleOut)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (sampleOut == '0 && !sampleValid)) else $error("reset state"); // R1
endmodule

// File: tb/fmVoiceBank_test.sv
module fmVoiceBank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleStrobe = 1'b0;
  logic [95:0] baseFcw = '0;
  logic [3:0]  noteOn = '0;
  logic [23:0] modFcw = '0;
  logic [3:0]  modShift = '0;
  logic signed [17:0] sampleOut;
  logic        sampleValid;

  int checks = 0;
  int fails = 0;
  logic [23:0] mp [4];
  logic [23:0] cp [4];

  always #5 clk = ~clk;

  fmVoiceBank uut (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe), .baseFcw(baseFcw),
    .noteOn(noteOn), .modFcw(modFcw), .modShift(modShift),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  function automatic int waveOf(logic [23:0] ph);
    int a = int'(ph[23:14]);
    int x = a % 512;
    int m = (x * (512 - x)) >>> 1;
    if (m > 32767) m = 32767;
    return (a >= 512) ? -m : m;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int modelStep();
    int total = 0;
    for (int v = 0; v < 4; v++) begin
      if (noteOn[v]) begin
        logic [23:0] ext;
        mp[v] = mp[v] + modFcw;
        ext = 24'(waveOf(mp[v]));
        cp[v] = cp[v] + baseFcw[v*24 +: 24] + (ext << modShift);
      end
      total += waveOf(cp[v]);
    end
    return total;
  endfunction

  task automatic doSample(string req);
    int expSum = modelStep();
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 valid early", int'(sampleValid), 0);
    @(negedge clk);
    check("R2 valid", int'(sampleValid), 1);
    check(req, int'(sampleOut), expSum);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int v = 0; v < 4; v++) begin mp[v] = '0; cp[v] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sampleOut", int'(sampleOut), 0);
    check("R1 sampleValid", int'(sampleValid), 0);
    doSample("R1 zero phases");

    // R7: walk every waveform address with one unmodulated voice
    noteOn = 4'b0001;
    baseFcw[23:0] = 24'h004000;
    for (int i = 0; i < 1024; i++) doSample("R7 waveform");
    @(negedge clk);
    check("R2 valid drops", int'(sampleValid), 0);

    // R3 R4 R5 R6: every enable pattern, every shift
    baseFcw = {24'h01A3C0, 24'h2F0011, 24'h0B7D55, 24'h123456};
    modFcw = 24'h03F2A1;
    for (int p = 0; p < 16; p++) begin
      noteOn = 4'(p);
      for (int s = 0; s < 16; s++) begin
        modShift = 4'(s);
        doSample("R4 R5 R6 modulated sum");
      end
    end

    // R3: large shared modulator word, negative modulator samples
    noteOn = 4'b1111;
    modFcw = 24'hA55A5A;
    modShift = 4'd15;
    for (int i = 0; i < 40; i++) doSample("R3 shared modulator");

    // R8: idle gap then sample continues from held state
    repeat (50) @(negedge clk);
    check("R8 output held", int'(sampleOut), waveOf(cp[0]) + waveOf(cp[1]) + waveOf(cp[2]) + waveOf(cp[3]));
    doSample("R8 after gap");

    // R5: all voices off, output unchanged by strobes
    noteOn = 4'b0000;
    for (int i = 0; i < 4; i++) doSample("R5 all off");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule